// File: doc/BRIEF.md
# Level Interrupt Aggregator with Command-Driven Mask

This block gathers the level-sensitive request lines of several peripherals into one CPU interrupt. Each request is brought into the block clock domain by a short flop chain and then shown in a read-only pending register. A mask register chooses which pending sources may reach the CPU line. The CPU line is high while at least one pending source is also enabled.

Software never writes mask bits as values. Instead, a write to the mask register carries two command bits per source. One bit sets that source's enable and the other clears it, so a driver can enable or disable one source without a read-modify-write sequence. A source is acknowledged at the source itself: the pending bit falls when the request line falls.

Registers sit at word offsets on a simple request/write-enable bus with combinational read data. The pending register is at word offset 2 and the mask register at word offset 3.

Top module: `irq_aggr`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every mask bit is 0, every pending bit is 0 and `irq_o` is 0.
- R2: Pending bit n equals the level of `src_i[n]` sampled SYNC_STAGES rising clock edges earlier. With the defaults it appears two edges after the input changes. A read at word offset 2 returns the pending bits in bits N_SRC-1:0.
- R3: A write to word offset 2 has no effect on the pending bits or the mask bits.
- R4: In a write to word offset 3, write-data bit 2n+1 set alone enables source n at the next edge. Example: writing 0x20 enables source 2, and a mask read then returns 0x04.
- R5: In a write to word offset 3, write-data bit 2n set alone disables source n at the next edge. Example: writing 0x10 disables source 2.
- R6: A source whose two command bits are both 1 or both 0 keeps its mask bit. The mask never changes except through a write to word offset 3.
- R7: A read at word offset 3 returns mask bit n in read-data bit n. Read-data bits above N_SRC-1 are always 0.
- R8: `irq_o` is 1 exactly when some source has both its pending bit and its mask bit at 1. It falls in the same cycle that the last such pair breaks.
- R9: Reads at any other offset, and cycles with no read request, return 0. Writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Level request lines from the peripherals |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word offset of the access |
| wdata_i | input | DATA_W | Write data; for the mask this carries clear/set command pairs |
| rdata_o | output | DATA_W | Read data, combinational, valid while a read is requested |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
A corrupted mask bit shows in two places. It appears on the very next mask read, and on `irq_o` in the first cycle its source is pending. A pending stage that is stuck or skipped shifts the moment the request appears, by one or more cycles, on both the pending read and the interrupt line. The bench therefore compares both outputs against a behavioural model on every clock, while random request levels and command writes run. Directed cases pin down the 0x20/0x10 commands for source 2, the both-bits and no-bits commands, and the writes that must do nothing.

// File: rtl/irq_aggr_pkg.sv
`timescale 1ns/1ps
package irq_aggr_pkg;
  localparam int unsigned OFF_PEND = 2;
  localparam int unsigned OFF_MASK = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_src_sync.sv
`timescale 1ns/1ps
module irq_src_sync #(
  parameter int unsigned N_SRC  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [N_SRC-1:0] d;
    if (s == 0) begin : g_first
      assign d = src_i;
    end else begin : g_next
      assign d = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= d;
    end
  end

  assign pend_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_mask_cmd.sv
`timescale 1ns/1ps
module irq_mask_cmd #(
  parameter int unsigned N_SRC  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_SRC-1:0]  mask_o
);
  localparam int unsigned CMD_W = 2 * N_SRC;

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    logic clr, set;
    assign clr = wdata_i[2*n];
    assign set = wdata_i[2*n+1];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[n] <= 1'b0;
      end else if (wr_i && (set ^ clr)) begin
        mask_o[n] <= set;
      end
    end
  end

  if (CMD_W < DATA_W) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^wdata_i[DATA_W-1:CMD_W];
  end
endmodule

// File: rtl/irq_rd_mux.sv
`timescale 1ns/1ps
module irq_rd_mux
  import irq_aggr_pkg::*;
#(
  parameter int unsigned N_SRC  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  reg_sel_e          sel_i,
  input  logic [N_SRC-1:0]  pend_i,
  input  logic [N_SRC-1:0]  mask_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_PEND: rdata_o[N_SRC-1:0] = pend_i;
      SEL_MASK: rdata_o[N_SRC-1:0] = mask_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggr.sv
`timescale 1ns/1ps
module irq_aggr
  import irq_aggr_pkg::*;
#(
  parameter int unsigned N_SRC       = 6,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);

  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] mask_q;
  logic             wr_mask;
  reg_sel_e         rd_sel;

  assign wr_mask = req_i && we_i && (addr_i == A_MASK);

  always_comb begin
    rd_sel = SEL_NONE;
    if (req_i && !we_i) begin
      if (addr_i == A_PEND)      rd_sel = SEL_PEND;
      else if (addr_i == A_MASK) rd_sel = SEL_MASK;
    end
  end

  irq_src_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .pend_o (pend_q)
  );

  irq_mask_cmd #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_mask),
    .wdata_i (wdata_i),
    .mask_o  (mask_q)
  );

  irq_rd_mux #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_rd (
    .sel_i   (rd_sel),
    .pend_i  (pend_q),
    .mask_i  (mask_q),
    .rdata_o (rdata_o)
  );

  assign irq_o = |(pend_q & mask_q);
endmodule

// File: rtl/irq_aggr_chk.sv
`timescale 1ns/1ps
module irq_aggr_chk #(
  parameter int unsigned N_SRC  = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [N_SRC-1:0]  pend_q,
  input logic [N_SRC-1:0]  mask_q
);
  logic             wr_m;
  logic [N_SRC-1:0] set_v, clr_v;

  assign wr_m = req_i && we_i && (addr_i == ADDR_W'(3));

  always_comb begin
    for (int n = 0; n < N_SRC; n++) begin
      clr_v[n] = wdata_i[2*n];
      set_v[n] = wdata_i[2*n+1];
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_MASK_RST: assert (mask_q == '0 && pend_q == '0 && !irq_o); // R1
    end
  end

  AST_SET_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_m |=> ((mask_q & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v))); // R4

  AST_CLR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_m |=> ((mask_q & $past(clr_v & ~set_v)) == '0)); // R5

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_m |=> (((mask_q ^ $past(mask_q)) & ~$past(set_v ^ clr_v)) == '0)); // R6

  AST_MASK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_m |=> $stable(mask_q)); // R6

  AST_RD_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:N_SRC] == '0); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0 || pend_q == '0) |-> !irq_o); // R8

  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> rdata_o == '0); // R9
endmodule

bind irq_aggr irq_aggr_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .pend_q  (pend_q),
  .mask_q  (mask_q)
);

// File: tb/irq_aggr_tb_top.sv
`timescale 1ns/1ps
module irq_aggr_tb_top;
  localparam int N  = 6;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int SY = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          irq_o;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  string phase = "R1";

  always #2.5 clk_i = ~clk_i;

  irq_aggr #(.N_SRC(N), .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SY)) dut_i (
    .clk_i, .rst_ni, .src_i, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  // behavioural reference
  logic [N-1:0] mask_m;
  logic [N-1:0] hist[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_m = '0;
      hist.delete();
    end else begin
      if (req_i && we_i && addr_i == 3) begin
        for (int n = 0; n < N; n++) begin
          if (wdata_i[2*n+1] && !wdata_i[2*n]) mask_m[n] = 1'b1;
          if (wdata_i[2*n] && !wdata_i[2*n+1]) mask_m[n] = 1'b0;
        end
      end
      hist.push_back(src_i);
      if (hist.size() > SY) void'(hist.pop_front());
    end
  end

  function automatic logic [N-1:0] pend_m();
    return (hist.size() == SY) ? hist[0] : '0;
  endfunction

  function automatic logic [DW-1:0] rd_m();
    logic [DW-1:0] r = '0;
    if (req_i && !we_i) begin
      if (addr_i == 2) r[N-1:0] = pend_m();
      else if (addr_i == 3) r[N-1:0] = mask_m;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk({phase, " irq"}, DW'(irq_o), DW'(|(pend_m() & mask_m)));
      chk({phase, " rdata"}, rdata_o, rd_m());
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    step();
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(string req, int a, logic [DW-1:0] exp);
    req_i = 1'b1; we_i = 1'b0; addr_i = AW'(a);
    @(negedge clk_i);
    chk(req, rdata_o, exp);
    step();
    req_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    // R1: values held under reset
    #7;
    chk("R1 irq in reset", DW'(irq_o), '0);
    rst_ni = 1'b1;
    step();
    rd("R1 mask after reset", 3, '0);
    rd("R1 pend after reset", 2, '0);
    chk("R1 irq after reset", DW'(irq_o), '0);

    phase = "R4";
    wr(3, 32'h20);
    rd("R4 set src2 via 0x20", 3, 32'h04);

    phase = "R2";
    src_i = 6'b000100;
    step();
    @(negedge clk_i);
    chk("R2 one edge not yet pending", DW'(irq_o), '0);
    step();
    rd("R2 pend src2 = 0x04", 2, 32'h04);
    phase = "R8";
    @(negedge clk_i);
    chk("R8 irq enabled+pending", DW'(irq_o), 1);
    step();

    phase = "R6";
    wr(3, 32'h30);
    rd("R6 both bits hold", 3, 32'h04);
    wr(3, 32'h0);
    rd("R6 no bits hold", 3, 32'h04);

    phase = "R3";
    wr(2, 32'hFFFF_FFFF);
    rd("R3 pend unchanged", 2, 32'h04);
    rd("R3 mask unchanged", 3, 32'h04);

    phase = "R5";
    wr(3, 32'h10);
    rd("R5 clr src2 via 0x10", 3, 32'h00);
    chk("R8 irq drops when masked", DW'(irq_o), '0);

    phase = "R7";
    wr(3, 32'hFFFF_F802);
    rd("R7 set src0 and src5 packed", 3, 32'h21);
    wr(3, 32'h1);
    rd("R7 clr src0 only", 3, 32'h20);

    phase = "R9";
    wr(5, 32'hAAA);
    rd("R9 odd write ignored", 3, 32'h20);
    rd("R9 other offset reads 0", 5, '0);
    rd("R9 offset 0 reads 0", 0, '0);

    phase = "R8";
    src_i = 6'b100000;
    repeat (SY) step();
    @(negedge clk_i);
    chk("R8 irq from src5", DW'(irq_o), 1);
    step();
    src_i = '0;
    repeat (SY) step();
    @(negedge clk_i);
    chk("R8 irq falls with source", DW'(irq_o), '0);
    step();

    // random traffic, reference compared every clock
    phase = "R2/R4/R5/R6/R8 random";
    for (int i = 0; i < 2000; i++) begin
      src_i  = N'($urandom);
      req_i  = $urandom_range(0, 3) != 0;
      we_i   = $urandom_range(0, 1) == 1;
      addr_i = AW'($urandom_range(0, 5));
      wdata_i = $urandom;
      step();
    end
    req_i = 1'b0;
    step();
    finish_run();
  end
endmodule